// File: doc/BRIEF.md
# I2S Philips-Standard Audio Transmitter

This block is the transmit side of an I2S master in the Philips framing. Software or a DMA engine hands it audio samples as 16-bit words over a ready/valid handshake. The block drives the serial clock, the word-select line and the serial data line. Samples alternate left then right, and every slot is sent most significant bit first. The serial clock is not generated internally: each pulse on an enable tick input flips the clock once, so an external divider sets the bit rate.

A two-bit format setting picks one of four sample/slot shapes. In the first, a 16-bit sample fills a 16-bit slot. In the second, a 16-bit sample is padded to a 32-bit slot. In the third, a 24-bit sample sits in a 32-bit slot. In the fourth, a 32-bit sample fills a 32-bit slot. Wide samples arrive as two consecutive writes, upper half first, and the block inserts the padding zeros itself. A channel-side output tells the feeder which channel the next sample belongs to. A sticky flag reports a slot that began before its sample was complete.

Top module: `i2s_tx`

## Requirements
- R1: While `enable` is low the outputs rest at `sck`=1, `ws`=0, `sd`=0, `wrReady`=0, `chanSide`=0, `underrun`=0.
- R2: While enabled, `sck` toggles once per `bitTick` pulse, one clock after the pulse, and never otherwise. The first pulse after enabling makes a falling edge.
- R3: `sd` and `ws` change only together with a falling edge of `sck`, so a receiver can sample them on the rising edge. Each slot is sent MSB first.
- R4: Format codes are 0 for 16-bit data in a 16-bit slot and 1 for 16-bit data in a 32-bit slot, where the write fills bits 31:16 and bits 15:0 are zero. Code 2 is 24-bit data in a 32-bit slot: the first write fills bits 31:16, the upper byte of the second write fills bits 15:8, and bits 7:0 are zero. Code 3 is 32-bit data: the first write fills bits 31:16 and the second fills bits 15:0.
- R5: `ws` is 0 for left and 1 for right. The first slot after enabling is left, and slots then alternate. `ws` takes the value of the next slot at the same falling edge that presents the last bit of the current slot, one `sck` period before the next MSB.
- R6: `wrReady` is high while the sample buffer still needs words. A sample takes one write in formats 0 and 1 and two writes in formats 2 and 3.
- R7: `chanSide` gives the channel of the next sample to be written. It is 0 right after enabling and toggles at every slot start.
- R8: If a slot starts before its sample is complete, that slot is sent as all zeros, any partial sample is dropped and `underrun` is set. `underrun` stays set until `enable` goes low.
- R9: A change of `fmt` while `enable` is high has no effect. The format is captured only while disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the interface; low returns it to idle |
| fmt | input | 2 | Sample/slot format code (R4) |
| bitTick | input | 1 | One-cycle pulse that advances the serial clock by half a period |
| wrData | input | 16 | Sample word from the feeder |
| wrValid | input | 1 | `wrData` is offered |
| wrReady | output | 1 | A word is accepted when this and `wrValid` are high |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 left, 1 right |
| sd | output | 1 | Serial data, MSB first |
| chanSide | output | 1 | Channel of the next sample to write, 0 left |
| underrun | output | 1 | Sticky flag for a slot that started without a full sample |

## Verification
Each of the four formats is run with a left and a right sample whose bit patterns differ at both ends and in the middle of the slot. A wrong slot length, a wrong half order, a missing pad or a swapped channel therefore each give a different captured bit stream. The word-select trace is compared bit by bit against the expected lead of one clock, which separates a correct Philips alignment from a justified or late one. Directed runs starve the buffer to force zero slots, change the format while running, and count writes per sample to check the ready behaviour.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {
    FMT_D16_S16 = 2'd0,
    FMT_D16_S32 = 2'd1,
    FMT_D24_S32 = 2'd2,
    FMT_D32_S32 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic load;   // start of a new slot: move buffer into shifter
    logic shift;  // next bit of the current slot
    logic idle;   // interface disabled: clear everything
  } strobe_t;

endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  fmt_e    fmtIn,
  input  logic    bitTick,
  output fmt_e    cfgFmt,
  output strobe_t st,
  output logic    sck,
  output logic    ws,
  output logic    chanSide
);

  localparam int SLOT_W = 2 * DATA_W;
  localparam int CNT_W  = $clog2(SLOT_W);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] nearLast;
  logic             started;
  logic             fallNow;

  assign lastIdx  = (cfgFmt == FMT_D16_S16) ? CNT_W'(DATA_W - 1) : CNT_W'(SLOT_W - 1);
  assign nearLast = lastIdx - CNT_W'(1);
  assign fallNow  = enable && bitTick && sck;

  always_comb begin
    st.idle  = !enable;
    st.load  = fallNow && (!started || (bitCnt == lastIdx));
    st.shift = fallNow && !st.load;
  end

  // format is only captured while the interface is stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgFmt <= FMT_D16_S16;
    else if (!enable) cfgFmt <= fmtIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck      <= 1'b1;
      ws       <= 1'b0;
      bitCnt   <= '0;
      started  <= 1'b0;
      chanSide <= 1'b0;
    end else if (!enable) begin
      sck      <= 1'b1;
      ws       <= 1'b0;
      bitCnt   <= '0;
      started  <= 1'b0;
      chanSide <= 1'b0;
    end else if (bitTick) begin
      sck <= ~sck;
      if (st.load) begin
        bitCnt   <= '0;
        started  <= 1'b1;
        chanSide <= ~chanSide;
      end else if (st.shift) begin
        bitCnt <= bitCnt + CNT_W'(1);
        // word select leads the next slot's MSB by one bit
        if (bitCnt == nearLast) ws <= ~ws;
      end
    end
  end

endmodule

// File: rtl/i2s_tx_datapath.sv
module i2s_tx_datapath
  import i2s_tx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  fmt_e              cfgFmt,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic              sd,
  output logic              underrun
);

  localparam int SLOT_W = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  logic [SLOT_W-1:0] holdBuf;
  logic [SLOT_W-1:0] shiftReg;
  logic [1:0]        wordCnt;
  logic [1:0]        wordsNeeded;
  logic              wrFire;
  logic              sampleFull;
  logic [DATA_W-1:0] lowHalf;

  assign wordsNeeded = (cfgFmt == FMT_D16_S16 || cfgFmt == FMT_D16_S32) ? 2'd1 : 2'd2;
  assign sampleFull  = (wordCnt == wordsNeeded);
  assign wrReady     = !st.idle && (wordCnt < wordsNeeded);
  assign wrFire      = wrValid && wrReady;
  assign sd          = shiftReg[SLOT_W-1];

  generate
    if (DATA_W >= 2) begin : g_pad
      assign lowHalf = (cfgFmt == FMT_D24_S32)
                     ? {wrData[DATA_W-1 -: HALF_W], {(DATA_W - HALF_W){1'b0}}}
                     : wrData;
    end else begin : g_nopad
      assign lowHalf = wrData;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdBuf  <= '0;
      shiftReg <= '0;
      wordCnt  <= '0;
      underrun <= 1'b0;
    end else if (st.idle) begin
      holdBuf  <= '0;
      shiftReg <= '0;
      wordCnt  <= '0;
      underrun <= 1'b0;
    end else if (st.load) begin
      shiftReg <= sampleFull ? holdBuf : '0;
      if (!sampleFull) underrun <= 1'b1;
      wordCnt  <= wrFire ? 2'd1 : 2'd0;
      holdBuf  <= wrFire ? {wrData, {DATA_W{1'b0}}} : '0;
    end else begin
      if (st.shift) shiftReg <= {shiftReg[SLOT_W-2:0], 1'b0};
      if (wrFire) begin
        if (wordCnt == 2'd0) holdBuf <= {wrData, {DATA_W{1'b0}}};
        else                 holdBuf[DATA_W-1:0] <= lowHalf;
        wordCnt <= wordCnt + 2'd1;
      end
    end
  end

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        fmt,
  input  logic              bitTick,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic              sck,
  output logic              ws,
  output logic              sd,
  output logic              chanSide,
  output logic              underrun
);

  strobe_t st;
  fmt_e    cfgFmt;

  i2s_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .fmtIn    (fmt_e'(fmt)),
    .bitTick  (bitTick),
    .cfgFmt   (cfgFmt),
    .st       (st),
    .sck      (sck),
    .ws       (ws),
    .chanSide (chanSide)
  );

  i2s_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .cfgFmt   (cfgFmt),
    .wrData   (wrData),
    .wrValid  (wrValid),
    .wrReady  (wrReady),
    .sd       (sd),
    .underrun (underrun)
  );

endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic bitTick,
  input logic wrReady,
  input logic sck,
  input logic ws,
  input logic sd,
  input logic chanSide,
  input logic underrun
);

  // R2
  sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$past(bitTick)) |-> $stable(sck));

  // R3
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !($past(bitTick) && $past(sck))) |-> $stable(sd));

  // R5
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$stable(ws)) |-> $fell(sck));

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!wrReady || enable));

  // R7
  side_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$stable(chanSide)) |-> $fell(sck));

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $past(underrun)) |-> underrun);

endmodule

bind i2s_tx i2s_tx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .bitTick  (bitTick),
  .wrReady  (wrReady),
  .sck      (sck),
  .ws       (ws),
  .sd       (sd),
  .chanSide (chanSide),
  .underrun (underrun)
);

// File: tb/test_i2s_tx.sv
`timescale 1ns/1ps
module test_i2s_tx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        bitTick = 1'b0;
  logic [15:0] wrData = '0;
  logic        wrValid = 1'b0;
  logic        wrReady, sck, ws, sd, chanSide, underrun;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  i2s_tx i_i2s_tx (
    .clk(clk), .rstN(rstN), .enable(enable), .fmt(fmt), .bitTick(bitTick),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady), .sck(sck),
    .ws(ws), .sd(sd), .chanSide(chanSide), .underrun(underrun)
  );

  // capture of sd/ws at each rising sck edge
  logic capSd [64];
  logic capWs [64];
  int   capN = 0;
  logic prevSck = 1'b1;

  always @(negedge clk) begin
    if (sck && !prevSck && capN < 64) begin
      capSd[capN] = sd;
      capWs[capN] = ws;
      capN = capN + 1;
    end
    prevSck = sck;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeWord(input logic [15:0] w);
    @(negedge clk);
    while (!wrReady) @(negedge clk);
    wrData  = w;
    wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic doTicks(input int n);
    for (int k = 0; k < n; k++) begin
      repeat (3) @(negedge clk);
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
    end
  endtask

  typedef struct packed {
    logic [1:0]  vf;
    logic [15:0] l0, l1, r0, r1;
    logic [31:0] expL, expR;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 16'hA5C3, 16'h0000, 16'h3C5A, 16'h0000, 32'hA5C30000, 32'h3C5A0000},
    '{2'd1, 16'h8001, 16'h0000, 16'h7FFE, 16'h0000, 32'h80010000, 32'h7FFE0000},
    '{2'd2, 16'h1234, 16'h56FF, 16'hFEDC, 16'hBA11, 32'h12345600, 32'hFEDCBA00},
    '{2'd3, 16'hDEAD, 16'hBEEF, 16'h0F0F, 16'hF0F1, 32'hDEADBEEF, 32'h0F0FF0F1},
    '{2'd0, 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 32'hFFFF0000, 32'h00010000}
  };

  initial begin
    #2_000_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle state out of reset
    check("R1", "reset idle", {26'd0, sck, ws, sd, wrReady, chanSide, underrun}, 32'b100000);
    rstN = 1'b1;
    @(negedge clk);

    // table of formats: R3 R4 R5 R8
    for (int v = 0; v < NVEC; v++) begin
      int slotLen;
      int wordsPer;
      logic wsOk;
      logic [31:0] gotL, gotR;
      slotLen  = (VECS[v].vf == 2'd0) ? 16 : 32;
      wordsPer = (VECS[v].vf >= 2'd2) ? 2 : 1;
      enable = 1'b0;
      fmt = VECS[v].vf;
      repeat (2) @(negedge clk);
      capN = 0;
      enable = 1'b1;
      writeWord(VECS[v].l0);
      if (wordsPer == 2) writeWord(VECS[v].l1);
      fork
        begin
          writeWord(VECS[v].r0);
          if (wordsPer == 2) writeWord(VECS[v].r1);
        end
        doTicks(4 * slotLen);
      join
      @(negedge clk);
      check("R2", "rising edge count", 32'(capN), 32'(2 * slotLen));
      gotL = '0;
      gotR = '0;
      wsOk = 1'b1;
      for (int i = 0; i < slotLen; i++) begin
        gotL[31 - i] = capSd[i];
        gotR[31 - i] = capSd[slotLen + i];
      end
      for (int i = 0; i < 2 * slotLen; i++)
        if (capWs[i] !== logic'(((i + 1) / slotLen) % 2)) wsOk = 1'b0;
      check("R4", $sformatf("left slot fmt %0d", VECS[v].vf), gotL, VECS[v].expL);
      check("R3", $sformatf("right slot MSB first fmt %0d", VECS[v].vf), gotR, VECS[v].expR);
      check("R5", $sformatf("ws lead pattern fmt %0d", VECS[v].vf), {31'd0, wsOk}, 32'd1);
      check("R8", "no underrun when fed", {31'd0, underrun}, 32'd0);
    end

    // directed: ready, side, format lock, underrun
    enable = 1'b0;
    fmt = 2'd0;
    repeat (2) @(negedge clk);
    check("R1", "disabled idle", {26'd0, sck, ws, sd, wrReady, chanSide, underrun}, 32'b100000);
    capN = 0;
    enable = 1'b1;
    @(negedge clk);
    check("R7", "side left after enable", {31'd0, chanSide}, 32'd0);
    check("R6", "ready when empty", {31'd0, wrReady}, 32'd1);
    writeWord(16'hC001);
    check("R6", "one write fills fmt 0", {31'd0, wrReady}, 32'd0);
    fmt = 2'd3;
    repeat (2) @(negedge clk);
    check("R9", "fmt change while enabled ignored", {31'd0, wrReady}, 32'd0);
    doTicks(1);
    check("R2", "first tick falls sck", {31'd0, sck}, 32'd0);
    check("R7", "side right after left load", {31'd0, chanSide}, 32'd1);
    doTicks(31);
    @(negedge clk);
    check("R9", "slot stays 16 bits", {31'd0, capWs[15]}, 32'd1);
    doTicks(2);
    @(negedge clk);
    check("R8", "underrun set on starved slot", {31'd0, underrun}, 32'd1);
    check("R8", "starved slot sends zero", {31'd0, capSd[16]}, 32'd0);
    check("R7", "side back to left", {31'd0, chanSide}, 32'd0);
    doTicks(4);
    check("R8", "underrun sticky", {31'd0, underrun}, 32'd1);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", "underrun cleared on disable", {31'd0, underrun}, 32'd0);
    check("R1", "sck idles high", {31'd0, sck}, 32'd1);

    // R6: two writes needed in fmt 3
    enable = 1'b1;
    writeWord(16'h1111);
    check("R6", "ready after one of two words", {31'd0, wrReady}, 32'd1);
    writeWord(16'h2222);
    check("R6", "not ready after two words", {31'd0, wrReady}, 32'd0);
    enable = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule